// File: doc/BRIEF.md
# SDRAM Command Spacing Guard

This block sits beside the command sequencer of a synchronous DRAM controller. It watches every command the sequencer issues and tells it, cycle by cycle, which kinds of command may legally go out next. It does not issue commands itself. The sequencer reads three permission flags and holds back any command whose flag is low.

A packed timing word supplies three fields: the precharge-to-activate gap, the activate-to-column gap and the write recovery delay. A mode input selects how write recovery is enforced. In auto-precharge mode, a write delays the next activate. In RAS-down mode, where rows stay open, a write delays only the next explicit precharge. Each timing window is tracked by its own small two-state machine. A machine is in IDLE when its window is open and in HOLD while it counts down. The transitions are:
- IDLE→HOLD on a triggering command whose gap is two or more cycles.
- HOLD→HOLD on a restart or on a count step.
- HOLD→IDLE when the count expires, or when a restarting command carries a gap of one cycle or less.

A configuration check flags reserved settings, and settings that are forbidden while RAS-down mode is active.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A precharge (`cmd_code` 11) sampled with precharge field `timing_cfg[2:0]` = p drops `act_ok` for the next p cycles, so activate is allowed again exactly p+1 cycles after the precharge.
- R2: An activate (`cmd_code` 00) drops `rw_ok` until k cycles after it. Field `timing_cfg[4:3]` gives k = 2, 3 and 4 for codes 01, 10 and 11. Code 00 gives k = 2.
- R3: In auto-precharge mode (`ras_down` = 0), a write (`cmd_code` 10) keeps `act_ok` low until (p+1)+w cycles after it. Here w is the write delay field `timing_cfg[7:5]`, and its code n means n cycles.
- R4: In RAS-down mode, a write keeps `pre_ok` low until w cycles after it. A w of 0 or 1 leaves `pre_ok` high.
- R5: `cfg_err` is high whenever the column-gap code is 00, in either mode.
- R6: With `ras_down` = 1, `cfg_err` is high for column-gap code 11 or precharge code 3 or more. Any other setting with a nonzero column-gap code gives `cfg_err` low in both modes.
- R7: During reset and in the first cycle after it, `act_ok`, `rw_ok` and `pre_ok` are all high.
- R8: A repeated triggering command restarts its window from the newest command, even when the new window is shorter. Timing fields are captured only at the triggering command, so a configuration change during a running window does not alter that window.
- R9: Reads, commands with `cmd_valid` low, writes in auto-precharge mode (for `pre_ok`) and writes in RAS-down mode (for `act_ok`) start no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_cfg | input | 8 | [2:0] precharge gap code, [4:3] activate-to-column code, [7:5] write delay code |
| ras_down | input | 1 | 1 selects RAS-down mode, 0 selects auto-precharge mode |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 2 | 00 activate, 01 read, 10 write, 11 precharge |
| act_ok | output | 1 | An activate may be issued this cycle |
| rw_ok | output | 1 | A read or write may be issued this cycle |
| pre_ok | output | 1 | A precharge may be issued this cycle |
| cfg_err | output | 1 | The current setting is reserved or forbidden in the current mode |

## Verification
A machine stuck in HOLD, or a count loaded off by one, shows up at the ports as a permission flag that opens one cycle early or late, or never opens. The per-clock reference comparison catches this in the first cycle the flag is wrong, and that cycle is at most fifteen cycles after the triggering command. A lost restart shows up in the same way: the permission reopens on the older command's schedule instead of the newest one's. A configuration check that is wrong shows up in the same cycle as the setting that exposes it.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } sdr_cmd_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_HOLD = 1'b1
    } tmr_state_e;

    localparam int unsigned NUM_WIN    = 4;
    localparam int unsigned WIN_PRE_ACT = 0;
    localparam int unsigned WIN_WR_ACT  = 1;
    localparam int unsigned WIN_ACT_RW  = 2;
    localparam int unsigned WIN_WR_PRE  = 3;

endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode #(
    parameter int unsigned PRE_W         = 3,
    parameter int unsigned RCD_W         = 2,
    parameter int unsigned WRD_W         = 3,
    parameter int unsigned CNT_W         = 4,
    parameter int unsigned RASDN_PRE_MAX = 2,
    localparam int unsigned CFG_W        = PRE_W + RCD_W + WRD_W
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             ras_down_i,
    output logic [CNT_W-1:0] pre_gap_o,
    output logic [CNT_W-1:0] rcd_gap_o,
    output logic [CNT_W-1:0] wr_act_gap_o,
    output logic [CNT_W-1:0] wr_pre_gap_o,
    output logic             cfg_err_o
);

    localparam logic [RCD_W-1:0] RCD_TOP = '1;

    logic [PRE_W-1:0] pre_c;
    logic [RCD_W-1:0] rcd_c;
    logic [WRD_W-1:0] wrd_c;
    logic [CNT_W-1:0] pre_n;
    logic             rsv_hit;
    logic             inh_hit;

    always_comb begin
        pre_c = cfg_i[PRE_W-1:0];
        rcd_c = cfg_i[PRE_W +: RCD_W];
        wrd_c = cfg_i[PRE_W+RCD_W +: WRD_W];
    end

    // gap lengths in clock cycles
    always_comb begin
        pre_n        = CNT_W'(pre_c) + CNT_W'(1);
        pre_gap_o    = pre_n;
        rcd_gap_o    = (rcd_c == '0) ? CNT_W'(2) : CNT_W'(rcd_c) + CNT_W'(1);
        wr_act_gap_o = pre_n + CNT_W'(wrd_c);
        wr_pre_gap_o = CNT_W'(wrd_c);
    end

    // reserved and mode-inhibited settings
    always_comb begin
        rsv_hit   = (rcd_c == '0);
        inh_hit   = ras_down_i &&
                    ((rcd_c == RCD_TOP) || (pre_c > PRE_W'(RASDN_PRE_MAX)));
        cfg_err_o = rsv_hit || inh_hit;
    end

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer
    import sdram_guard_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] gap_i,
    output logic             open_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             long_gap;

    always_comb begin
        long_gap = (gap_i > CNT_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (load_i && long_gap) begin
                    state_d = TMR_HOLD;
                    cnt_d   = gap_i - CNT_W'(1);
                end
            end
            TMR_HOLD: begin
                if (load_i) begin
                    if (long_gap) begin
                        state_d = TMR_HOLD;
                        cnt_d   = gap_i - CNT_W'(1);
                    end else begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        open_o = (state_q == TMR_IDLE);
    end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int unsigned PRE_W         = 3,
    parameter int unsigned RCD_W         = 2,
    parameter int unsigned WRD_W         = 3,
    parameter int unsigned RASDN_PRE_MAX = 2,
    localparam int unsigned CFG_W        = PRE_W + RCD_W + WRD_W,
    localparam int unsigned CNT_W        = $clog2((1 << PRE_W) + (1 << WRD_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic             ras_down,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    output logic             act_ok,
    output logic             rw_ok,
    output logic             pre_ok,
    output logic             cfg_err
);

    logic [CNT_W-1:0]   pre_gap, rcd_gap, wr_act_gap, wr_pre_gap;
    logic [CNT_W-1:0]   win_gap  [NUM_WIN];
    logic [NUM_WIN-1:0] win_load;
    logic [NUM_WIN-1:0] win_open;
    logic               is_act, is_wr, is_pre;

    sdram_cfg_decode #(
        .PRE_W         (PRE_W),
        .RCD_W         (RCD_W),
        .WRD_W         (WRD_W),
        .CNT_W         (CNT_W),
        .RASDN_PRE_MAX (RASDN_PRE_MAX)
    ) u_decode (
        .cfg_i        (timing_cfg),
        .ras_down_i   (ras_down),
        .pre_gap_o    (pre_gap),
        .rcd_gap_o    (rcd_gap),
        .wr_act_gap_o (wr_act_gap),
        .wr_pre_gap_o (wr_pre_gap),
        .cfg_err_o    (cfg_err)
    );

    always_comb begin
        is_act = cmd_valid && (cmd_code == CMD_ACT);
        is_wr  = cmd_valid && (cmd_code == CMD_WR);
        is_pre = cmd_valid && (cmd_code == CMD_PRE);
    end

    // route each command to the windows it opens
    always_comb begin
        win_load[WIN_PRE_ACT] = is_pre;
        win_load[WIN_WR_ACT]  = is_wr && !ras_down;
        win_load[WIN_ACT_RW]  = is_act;
        win_load[WIN_WR_PRE]  = is_wr && ras_down;
        win_gap[WIN_PRE_ACT]  = pre_gap;
        win_gap[WIN_WR_ACT]   = wr_act_gap;
        win_gap[WIN_ACT_RW]   = rcd_gap;
        win_gap[WIN_WR_PRE]   = wr_pre_gap;
    end

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        sdram_gap_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (win_load[gi]),
            .gap_i  (win_gap[gi]),
            .open_o (win_open[gi])
        );
    end

    always_comb begin
        act_ok = win_open[WIN_PRE_ACT] && win_open[WIN_WR_ACT];
        rw_ok  = win_open[WIN_ACT_RW];
        pre_ok = win_open[WIN_WR_PRE];
    end

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk #(
    parameter int unsigned PRE_W = 3,
    parameter int unsigned RCD_W = 2,
    parameter int unsigned WRD_W = 3,
    localparam int unsigned CFG_W = PRE_W + RCD_W + WRD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] timing_cfg,
    input logic             ras_down,
    input logic             cmd_valid,
    input logic [1:0]       cmd_code,
    input logic             act_ok,
    input logic             rw_ok,
    input logic             pre_ok,
    input logic             cfg_err
);

    logic [PRE_W-1:0] pre_c;
    logic [RCD_W-1:0] rcd_c;
    logic [WRD_W-1:0] wrd_c;

    always_comb begin
        pre_c = timing_cfg[PRE_W-1:0];
        rcd_c = timing_cfg[PRE_W +: RCD_W];
        wrd_c = timing_cfg[PRE_W+RCD_W +: WRD_W];
    end

    p_act_hold_after_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b11 && pre_c != '0) |=> !act_ok);

    p_rw_hold_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b00) |=> !rw_ok);

    p_act_hold_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b10 && !ras_down && (pre_c != '0 || wrd_c != '0))
        |=> !act_ok);

    p_pre_hold_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b10 && ras_down && wrd_c > WRD_W'(1)) |=> !pre_ok);

    p_reserved_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rcd_c == '0) |-> cfg_err);

    p_legal_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_down && rcd_c != '0) |-> !cfg_err);

    p_reset_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_ok && rw_ok && pre_ok));

    p_rw_stays_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_ok && !(cmd_valid && cmd_code == 2'b00)) |=> rw_ok);

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(
    .PRE_W (PRE_W),
    .RCD_W (RCD_W),
    .WRD_W (WRD_W)
) u_chk (.*);

// File: tb/tb_sdram_cmd_guard.sv
module tb_sdram_cmd_guard;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] timing_cfg;
    logic       ras_down;
    logic       cmd_valid;
    logic [1:0] cmd_code;
    logic       act_ok, rw_ok, pre_ok, cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int nx_pre_act = 0, nx_wr_act = 0, nx_act_rw = 0, nx_wr_pre = 0;
    string phase = "sweep";

    always #2 clk = ~clk;

    sdram_cmd_guard dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .timing_cfg (timing_cfg),
        .ras_down   (ras_down),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .act_ok     (act_ok),
        .rw_ok      (rw_ok),
        .pre_ok     (pre_ok),
        .cfg_err    (cfg_err)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d cfg %h mode %0b: got %0b expected %0b",
                     tag, phase, cyc, timing_cfg, ras_down, got, exp);
        end
    endtask

    // compare every output against the behavioural model for cycle cyc
    task automatic compare();
        int  p = int'(timing_cfg[2:0]);
        int  r = int'(timing_cfg[4:3]);
        logic e_err;
        chk(act_ok, (cyc >= nx_pre_act) && (cyc >= nx_wr_act),
            (nx_wr_act > nx_pre_act) ? "R3 act_ok" : "R1 act_ok");
        chk(rw_ok, cyc >= nx_act_rw, "R2 rw_ok");
        chk(pre_ok, cyc >= nx_wr_pre, "R4 pre_ok");
        e_err = (r == 0) || (ras_down && (r == 3 || p > 2));
        chk(cfg_err, e_err, (r == 0) ? "R5 cfg_err" : "R6 cfg_err");
    endtask

    // one clock: drive at negedge, update model at posedge, compare at negedge
    task automatic step(input logic v, input logic [1:0] c);
        int pg, rg, wd;
        cmd_valid = v;
        cmd_code  = c;
        @(posedge clk);
        pg = int'(timing_cfg[2:0]) + 1;
        rg = (timing_cfg[4:3] == 2'b00) ? 2 : int'(timing_cfg[4:3]) + 1;
        wd = int'(timing_cfg[7:5]);
        if (v) begin
            case (c)
                2'b00: nx_act_rw = cyc + rg;
                2'b11: nx_pre_act = cyc + pg;
                2'b10: begin
                    if (!ras_down) nx_wr_act = cyc + pg + wd;
                    else           nx_wr_pre = cyc + wd;
                end
                default: ;
            endcase
        end
        cyc++;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        timing_cfg = 8'h08;
        ras_down   = 1'b0;
        cmd_valid  = 1'b0;
        cmd_code   = 2'b00;
        repeat (3) @(negedge clk);
        // R7: flags open while reset is held
        phase = "reset";
        chk(act_ok, 1'b1, "R7 act_ok");
        chk(rw_ok,  1'b1, "R7 rw_ok");
        chk(pre_ok, 1'b1, "R7 pre_ok");
        rst_n = 1'b1;
        cyc = 0;
        idle(1);

        // R1..R6: every code in both modes, back-to-back commands
        phase = "sweep";
        for (int m = 0; m < 2; m++) begin
            for (int cv = 0; cv < 256; cv++) begin
                ras_down   = m[0];
                timing_cfg = cv[7:0];
                step(1'b1, 2'b00);
                step(1'b1, 2'b01);
                step(1'b1, 2'b10);
                step(1'b1, 2'b11);
                step(1'b1, 2'b00);
                step(1'b1, 2'b10);
                step(1'b1, 2'b10);
                idle(16);
            end
        end

        // R8: mid-window config change does not shorten a running window
        phase = "R8 capture";
        ras_down   = 1'b0;
        timing_cfg = 8'h0F;
        step(1'b1, 2'b11);
        timing_cfg = 8'h08;
        idle(9);
        // R8: a shorter restart replaces a longer window
        phase = "R8 restart";
        timing_cfg = 8'h0F;
        step(1'b1, 2'b11);
        timing_cfg = 8'h08;
        step(1'b1, 2'b11);
        idle(3);
        timing_cfg = 8'hF8;
        step(1'b1, 2'b10);
        timing_cfg = 8'h08;
        step(1'b1, 2'b10);
        idle(3);

        // R9: reads, invalid strobes and mode-mismatched writes start nothing
        phase = "R9 no window";
        timing_cfg = 8'hFB;
        step(1'b0, 2'b00);
        step(1'b0, 2'b11);
        step(1'b1, 2'b01);
        step(1'b1, 2'b10);
        idle(2);
        ras_down = 1'b1;
        idle(12);
        step(1'b1, 2'b10);
        idle(10);

        // random traffic with configuration and mode changes
        phase = "random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) timing_cfg = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 31) == 0) ras_down = ~ras_down;
            step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule